// File: doc/BRIEF.md
# Strong-Pixel Signal-to-Noise Comparator

This block decides, one pixel at a time, whether a detector pixel stands out from its local background strongly enough to be a spot candidate. For each pixel it receives the pixel value together with two statistics of the square box centred on it: the plain sum of the box and the sum of its squares. It also receives a squared threshold in fixed point, prepared outside the block. It answers with a single strong/not-strong flag.

The test it applies is "distance from the box mean, in units of the box standard deviation, is strictly above the threshold". No division and no square root are used. The box population `N = (2*NBX+1)^2` is folded into scaled integer quantities, and both sides of the test are squared. This keeps the decision exact, so it agrees with a double-precision evaluation of the same formula. The datapath is a three-register pipeline that accepts one pixel per clock. It has a valid/ready handshake on both sides and stalls as a whole under back-pressure.

Top module: `strongpix_cmp`

## Requirements
- R1: With `N = (2*NBX+1)^2`, the scaled excess is `d = N*value - sum`, where `value` and `sum` are two's complement. The flag is 0 whenever `d <= 0`.
- R2: The spread is `v = N*sum2 - sum*sum`, where `sum2` is unsigned and `t2` is unsigned with 8 fractional bits (256 = 1.0). When `d > 0` and `v > 0`, the flag is 1 exactly when `256*d*d > t2*v`. Equality gives 0.
- R3: When `d > 0` and `v <= 0`, the flag is 1 whatever the value of `t2`.
- R4: A pixel accepted while `en` is low yields flag 0. It still produces its output slot, in order.
- R5: A pixel accepted at a clock edge appears on `out_valid`/`out_flag` after the third edge, counting that edge, when `out_ready` is high. With `out_ready` held high, one pixel is accepted every cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_flag` hold and `in_ready` is low. Results leave in acceptance order, with none lost or duplicated.
- R7: During and right after reset `out_valid` is 0 and `in_ready` is 1. `out_flag` is 0 whenever `out_valid` is 0.
- R8: Take a box holding one pixel of value `x` plus `N-1` pixels of value 10. Set `t2` to 256, 2304 or 9216. For every `x` from -100 to 32766, the flag equals the double-precision test `(x - sum/N) / sqrt(sum2/N - (sum/N)^2) > t` with t = 1, 3 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sampled with each accepted pixel; low forces that pixel's flag to 0 |
| in_valid | input | 1 | Pixel and statistics are present |
| in_ready | output | 1 | Block takes the pixel at this edge |
| in_value | input | PIX_W (16) | Pixel value, two's complement |
| in_sum | input | SUM_W (22) | Box sum, two's complement |
| in_sum2 | input | SQ2_W (38) | Box sum of squares, unsigned |
| in_t2 | input | T2_W (16) | Squared threshold, unsigned, T2_FRAC (8) fractional bits |
| out_valid | output | 1 | A decision is present |
| out_ready | input | 1 | Downstream takes the decision |
| out_flag | output | 1 | 1 = strong pixel |

## Verification
The bench builds the block with its defaults: NBX = 3 (a 49-pixel box), 16-bit pixels, and a 16-bit squared threshold with 8 fractional bits. These widths leave every bound within reach. The bench drives the most negative and most positive value, sum and sum-of-squares codes to exercise the widest products, and places exact equality of the two squared sides within one code of the threshold. The box size makes the full uniform-background sweep against a floating-point model affordable for all three thresholds. Random back-pressure then exercises stalls on every pipeline stage with mixed enable.

// File: rtl/strongpix_pkg.sv
package strongpix_pkg;

  function automatic int box_count(input int half_width);
    return (2 * half_width + 1) * (2 * half_width + 1);
  endfunction

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strongpix_moments.sv
// Stage 1: scaled excess d = N*value - sum and scaled spread N*sum2 - sum^2.
module strongpix_moments #(
  parameter int NBX   = 3,
  parameter int PIX_W = 16,
  parameter int SUM_W = 22,
  parameter int SQ2_W = 38,
  parameter int T2_W  = 16,
  parameter int D_W   = 29,
  parameter int VAR_W = 46
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    v_in,
  input  logic                    en_in,
  input  logic signed [PIX_W-1:0] value,
  input  logic signed [SUM_W-1:0] sum,
  input  logic        [SQ2_W-1:0] sum2,
  input  logic        [T2_W-1:0]  t2,
  output logic                    v_q,
  output logic                    en_q,
  output logic signed [D_W-1:0]   d_q,
  output logic signed [VAR_W-1:0] var_q,
  output logic        [T2_W-1:0]  t2_q
);
  import strongpix_pkg::*;

  localparam int NWIN = box_count(NBX);
  localparam logic signed [D_W-1:0]   ND = D_W'(NWIN);
  localparam logic signed [VAR_W-1:0] NV = VAR_W'(NWIN);

  logic signed [D_W-1:0]   d_c;
  logic signed [VAR_W-1:0] s_ext, s2_ext, var_c;

  always_comb begin
    d_c    = ND * D_W'(value) - D_W'(sum);
    s_ext  = VAR_W'(sum);
    s2_ext = VAR_W'($signed({1'b0, sum2}));
    var_c  = NV * s2_ext - s_ext * s_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (adv) begin
      v_q <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      en_q  <= en_in;
      d_q   <= d_c;
      var_q <= var_c;
      t2_q  <= t2;
    end
  end

endmodule

// File: rtl/strongpix_products.sv
// Stage 2: both sides of the squared comparison plus the sign tests.
module strongpix_products #(
  parameter int D_W     = 29,
  parameter int VAR_W   = 46,
  parameter int T2_W    = 16,
  parameter int T2_FRAC = 8,
  parameter int CMP_W   = 66
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    v_in,
  input  logic                    en_in,
  input  logic signed [D_W-1:0]   d_in,
  input  logic signed [VAR_W-1:0] var_in,
  input  logic        [T2_W-1:0]  t2_in,
  output logic                    v_q,
  output logic                    en_q,
  output logic                    dpos_q,
  output logic                    vpos_q,
  output logic        [CMP_W-1:0] lhs_q,
  output logic        [CMP_W-1:0] rhs_q
);
  logic [D_W-1:0]   d_mag;
  logic [CMP_W-1:0] lhs_c, rhs_c;
  logic             dpos_c, vpos_c;

  always_comb begin
    dpos_c = (d_in > 0);
    vpos_c = (var_in > 0);
    d_mag  = d_in[D_W-1] ? $unsigned(-d_in) : $unsigned(d_in);
    lhs_c  = (CMP_W'(d_mag) * CMP_W'(d_mag)) << T2_FRAC;
    rhs_c  = vpos_c ? CMP_W'(t2_in) * CMP_W'($unsigned(var_in)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (adv) begin
      v_q <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      en_q   <= en_in;
      dpos_q <= dpos_c;
      vpos_q <= vpos_c;
      lhs_q  <= lhs_c;
      rhs_q  <= rhs_c;
    end
  end

endmodule

// File: rtl/strongpix_decide.sv
// Stage 3: final registered decision.
module strongpix_decide #(
  parameter int CMP_W = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             v_in,
  input  logic             en_in,
  input  logic             dpos_in,
  input  logic             vpos_in,
  input  logic [CMP_W-1:0] lhs_in,
  input  logic [CMP_W-1:0] rhs_in,
  output logic             v_q,
  output logic             flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      flag_q <= 1'b0;
    end else if (adv) begin
      v_q    <= v_in;
      flag_q <= v_in && en_in && dpos_in && (!vpos_in || (lhs_in > rhs_in));
    end
  end

  // R4
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in && !en_in) |=> !flag_q);

  // R1
  nonpositive_excess_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in && !dpos_in) |=> !flag_q);

  // R3
  flat_spread_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in && en_in && dpos_in && !vpos_in) |=> flag_q);

  // R2
  strict_tie_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in && vpos_in && (lhs_in <= rhs_in)) |=> !flag_q);

endmodule

// File: rtl/strongpix_cmp.sv
module strongpix_cmp #(
  parameter int NBX     = 3,
  parameter int PIX_W   = 16,
  parameter int SUM_W   = PIX_W + $clog2((2 * NBX + 1) * (2 * NBX + 1)),
  parameter int SQ2_W   = 2 * PIX_W + $clog2((2 * NBX + 1) * (2 * NBX + 1)),
  parameter int T2_W    = 16,
  parameter int T2_FRAC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_value,
  input  logic [SUM_W-1:0] in_sum,
  input  logic [SQ2_W-1:0] in_sum2,
  input  logic [T2_W-1:0]  in_t2,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_flag
);
  import strongpix_pkg::*;

  localparam int NWIN  = box_count(NBX);
  localparam int LOGN  = $clog2(NWIN);
  localparam int D_W   = SUM_W + LOGN + 1;
  localparam int VAR_W = SQ2_W + LOGN + 2;
  localparam int CMP_W = wider(2 * D_W + T2_FRAC, T2_W + VAR_W);

  logic adv;
  logic v1, en1, v2, en2, dpos2, vpos2;
  logic signed [D_W-1:0]   d1;
  logic signed [VAR_W-1:0] var1;
  logic [T2_W-1:0]         t2_1;
  logic [CMP_W-1:0]        lhs2, rhs2;

  // Whole pipeline moves together; it only stops when a result is refused.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  strongpix_moments #(
    .NBX(NBX), .PIX_W(PIX_W), .SUM_W(SUM_W), .SQ2_W(SQ2_W),
    .T2_W(T2_W), .D_W(D_W), .VAR_W(VAR_W)
  ) u_moments (
    .clk(clk), .rst(rst), .adv(adv), .v_in(in_valid), .en_in(en),
    .value($signed(in_value)), .sum($signed(in_sum)), .sum2(in_sum2), .t2(in_t2),
    .v_q(v1), .en_q(en1), .d_q(d1), .var_q(var1), .t2_q(t2_1)
  );

  strongpix_products #(
    .D_W(D_W), .VAR_W(VAR_W), .T2_W(T2_W), .T2_FRAC(T2_FRAC), .CMP_W(CMP_W)
  ) u_products (
    .clk(clk), .rst(rst), .adv(adv), .v_in(v1), .en_in(en1),
    .d_in(d1), .var_in(var1), .t2_in(t2_1),
    .v_q(v2), .en_q(en2), .dpos_q(dpos2), .vpos_q(vpos2),
    .lhs_q(lhs2), .rhs_q(rhs2)
  );

  strongpix_decide #(
    .CMP_W(CMP_W)
  ) u_decide (
    .clk(clk), .rst(rst), .adv(adv), .v_in(v2), .en_in(en2),
    .dpos_in(dpos2), .vpos_in(vpos2), .lhs_in(lhs2), .rhs_in(rhs2),
    .v_q(out_valid), .flag_q(out_flag)
  );

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flag)));

  // R7
  flag_gated_chk: assert property (@(posedge clk) disable iff (rst)
    out_flag |-> out_valid);

endmodule

// File: tb/tb_strongpix_cmp.sv
module tb_strongpix_cmp;
  import strongpix_pkg::*;

  localparam int NBX   = 3;
  localparam int PIX_W = 16;
  localparam int NWIN  = box_count(NBX);
  localparam int SUM_W = PIX_W + $clog2(NWIN);
  localparam int SQ2_W = 2 * PIX_W + $clog2(NWIN);
  localparam int T2_W  = 16;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_flag;
  logic [PIX_W-1:0] in_value = '0;
  logic [SUM_W-1:0] in_sum = '0;
  logic [SQ2_W-1:0] in_sum2 = '0;
  logic [T2_W-1:0]  in_t2 = '0;

  int checks = 0, fails = 0, cyc = 0;
  bit stall_mode = 1'b0, done = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  strongpix_cmp #(.NBX(NBX), .PIX_W(PIX_W), .SUM_W(SUM_W), .SQ2_W(SQ2_W),
                  .T2_W(T2_W), .T2_FRAC(8)) dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_sum(in_sum), .in_sum2(in_sum2), .in_t2(in_t2),
    .out_valid(out_valid), .out_ready(out_ready), .out_flag(out_flag));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Integer model of the requirements (R1, R2, R3, R4).
  function automatic bit model(input logic signed [PIX_W-1:0] v, input logic signed [SUM_W-1:0] s,
                               input logic [SQ2_W-1:0] s2, input logic [T2_W-1:0] t, input bit e);
    logic signed [127:0] n, d, vn, sw, vw;
    n  = 128'(NWIN);
    vw = 128'(v);
    sw = 128'(s);
    d  = n * vw - sw;
    vn = n * $signed({1'b0, 128'(s2)}) - sw * sw;
    if (!e || d <= 0) return 1'b0;
    if (vn <= 0) return 1'b1;
    return (d * d * 256) > ($signed({1'b0, 128'(t)}) * vn);
  endfunction

  // Floating-point reference for the uniform background case (R8).
  function automatic bit fp_ref(input int x, input real th);
    real n, s, s2, m, m2, sg;
    n  = real'(NWIN);
    s  = real'(x + (NWIN - 1) * 10);
    s2 = real'(longint'(x) * x + (NWIN - 1) * 100);
    m  = s / n;
    m2 = s2 / n;
    sg = $sqrt(m2 - m * m);
    return ((real'(x) - m) / sg) > th;
  endfunction

  // Driver: presents one pixel, pushes its expected flag when it is taken.
  task automatic send(input logic [PIX_W-1:0] v, input logic [SUM_W-1:0] s,
                      input logic [SQ2_W-1:0] s2, input logic [T2_W-1:0] t,
                      input bit e, input bit expf, input string tag);
    in_valid = 1'b1; in_value = v; in_sum = s; in_sum2 = s2; in_t2 = t; en = e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(expf);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_m(input logic [PIX_W-1:0] v, input logic [SUM_W-1:0] s,
                        input logic [SQ2_W-1:0] s2, input logic [T2_W-1:0] t,
                        input bit e, input string tag);
    send(v, s, s2, t, e, model($signed(v), $signed(s), s2, t, e), tag);
  endtask

  // Output back-pressure generator.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard.
  bit prev_stall = 1'b0, prev_flag = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_stall)
          check(out_valid && (out_flag == prev_flag), "R6 hold", int'(out_flag), int'(prev_flag));
        if (!out_valid)
          check(!out_flag, "R7 idle flag", int'(out_flag), 0);
        if (out_valid && !out_ready)
          check(!in_ready, "R6 in_ready", int'(in_ready), 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected output", 1, 0);
          end else begin
            bit ef;
            string tg;
            ef = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(out_flag == ef, tg, int'(out_flag), int'(ef));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_flag  = out_flag;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired, %0d results outstanding", exp_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready && !out_flag, "R7 in reset", int'(out_valid), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R7 after reset", int'(out_valid), 0);
    @(posedge clk); #1;

    // R5 latency: accepted at one edge, visible after the third.
    in_valid = 1'b1; in_value = 16'sd100; in_sum = SUM_W'(480); in_sum2 = SQ2_W'(4800);
    in_t2 = 16'd256; en = 1'b1;
    @(negedge clk);
    exp_q.push_back(1'b1); tag_q.push_back("R5 latency value");
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk); check(!out_valid, "R5 latency edge1", int'(out_valid), 0);
    @(negedge clk); check(!out_valid, "R5 latency edge2", int'(out_valid), 0);
    @(negedge clk); check(out_valid, "R5 latency edge3", int'(out_valid), 1);
    @(posedge clk); #1;

    // R1: non-positive excess.
    send(16'sd0, SUM_W'(7), SQ2_W'(0), 16'd0, 1'b1, 1'b0, "R1 d<0 flat");
    send(16'sd1, SUM_W'(49), SQ2_W'(49), 16'd0, 1'b1, 1'b0, "R1 d=0");
    // R2: exact equality of both sides is not strong; one code lower is.
    send(16'sd0, -SUM_W'(7), SQ2_W'(2), 16'd256, 1'b1, 1'b0, "R2 tie");
    send(16'sd0, -SUM_W'(7), SQ2_W'(2), 16'd255, 1'b1, 1'b1, "R2 below tie");
    // R3: zero and negative spread.
    send(16'sd0, -SUM_W'(7), SQ2_W'(1), 16'hFFFF, 1'b1, 1'b1, "R3 zero spread");
    send(16'sd0, -SUM_W'(7), SQ2_W'(0), 16'hFFFF, 1'b1, 1'b1, "R3 negative spread");
    // R4: a clearly strong pixel with enable low.
    send(16'sd20000, SUM_W'(20480), SQ2_W'(400004800), 16'd256, 1'b0, 1'b0, "R4 enable low");
    send(16'sd20000, SUM_W'(20480), SQ2_W'(400004800), 16'd256, 1'b1, 1'b1, "R4 enable high");
    // R2: extreme codes.
    send_m(16'h7FFF, {1'b1, {(SUM_W-1){1'b0}}}, '1, 16'hFFFF, 1'b1, "R2 extreme high");
    send_m(16'h8000, {1'b0, {(SUM_W-1){1'b1}}}, '1, 16'hFFFF, 1'b1, "R2 extreme low");
    send_m(16'h7FFF, {1'b1, {(SUM_W-1){1'b0}}}, '0, 16'h0001, 1'b1, "R2 extreme flat");

    // R8 sweep; the first pass also checks one pixel per cycle (R5).
    for (int k = 0; k < 3; k++) begin
      real th;
      int c0;
      th = (k == 0) ? 1.0 : ((k == 1) ? 3.0 : 6.0);
      c0 = cyc;
      for (int x = -100; x < 32767; x++) begin
        send(PIX_W'(x), SUM_W'(x + (NWIN - 1) * 10), SQ2_W'(longint'(x) * x + (NWIN - 1) * 100),
             T2_W'(int'(th * th * 256.0)), 1'b1, fp_ref(x, th), "R8 sweep");
      end
      if (k == 0) check((cyc - c0) == 32867, "R5 throughput", cyc - c0, 32867);
    end

    // Random traffic under back-pressure (R2, R4, R6).
    stall_mode = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      int b, x, nz;
      b  = int'($urandom % 200);
      x  = int'($urandom % 4000) - 500;
      nz = int'($urandom % 64) - 32;
      send_m(PIX_W'(x), SUM_W'(x + (NWIN - 1) * b + nz),
             SQ2_W'(longint'(x) * x + (NWIN - 1) * b * b + int'($urandom % 2000)),
             T2_W'($urandom % 9300), (($urandom % 5) != 0), "R2 R4 R6 random");
    end
    stall_mode = 1'b0;

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule